// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is a synchronous master for a micro-power converter that returns its conversion result on one serial data line. It runs from a fast system clock and divides it down to a serial clock. On a start request it pulls chip-select low and waits through the sampling setup. It then clocks out one frame, checks and strips the leading zero bits, and presents the result with a one-cycle valid strobe. After the frame it keeps chip-select high for a minimum interval before it opens the next frame.

The converter resolution is a parameter (12, 10 or 8 bits). The frame length follows from it: every frame carries four leading bits in front of the result, so the frame is 16, 14 or 12 clocks long. The serial clock half period, the setup delay after chip-select falls and the minimum chip-select high time are all parameters counted in system clock cycles. A start request that arrives while a frame or the high interval is still running is remembered and served as soon as the interval allows.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `cs_n` and `sclk` are 1, `result_valid` and `frame_err` are 0, and no start request seen before or during reset leads to a frame.
- R2: A `start` sampled high while the controller is idle drives `cs_n` low on the same clock edge, and `sclk` first falls exactly SETUP_CYC system cycles after `cs_n` fell.
- R3: While `cs_n` is low, every low phase and every high phase of `sclk` lasts exactly HALF_DIV system cycles, and `sclk` is 1 whenever `cs_n` is 1.
- R4: A frame contains exactly RES_BITS+4 falling edges of `sclk`: 16 at 12 bits, 14 at 10 bits and 12 at 8 bits.
- R5: The converter drives the k-th frame bit on `sdo_i` after the k-th falling edge of `sclk`, and the controller samples it on the next rising edge. Bits 1 to 4 are the leading bits. Bits 5 to RES_BITS+4 form `result`, MSB first.
- R6: `cs_n` rises HALF_DIV cycles after the last rising edge of `sclk`. `result_valid` is high for exactly that one cycle, and `result` then holds its value until the next valid strobe.
- R7: `frame_err` is high together with `result_valid` when any of the four leading bits was read as 1, and it is never high at any other time. The result is still delivered.
- R8: Between two frames, `cs_n` stays high for at least GAP_CYC system cycles.
- R9: A `start` that arrives during a frame or during the high interval is kept pending, so `cs_n` falls exactly GAP_CYC cycles after it rose. Several such requests open only one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request for one conversion frame |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip-select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| result | output | RES_BITS | Last captured conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| frame_err | output | 1 | One-cycle flag: a leading bit was nonzero |

## Verification
All outputs are registered. `cs_n` falls on the edge that samples `start` (or, for a pending request, GAP_CYC edges after `cs_n` rose). The first `sclk` fall comes SETUP_CYC edges after that, and each further `sclk` transition comes HALF_DIV edges after the previous one. `cs_n`, `result`, `result_valid` and `frame_err` all change on the edge that lies HALF_DIV cycles after the last rising `sclk`. The bench samples on falling system clock edges and counts cycles between the transitions it observes, then compares those counts with the exact figures above. A behavioural converter model drives the data line from falling `sclk` edges, so the data always changes well before the controller samples it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   // number of leading bits the converter sends in front of each result
   localparam int LEAD_BITS = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2,
      ST_GAP   = 2'd3
   } rd_state_t;

endpackage

// File: rtl/adc_rd_span.sv
// Counts cycles while enabled; last is high in the LIMIT-th enabled cycle.
module adc_rd_span #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic en,
   output logic last
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   assign last = (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt_q <= '0;
      end else if (en && !last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/adc_rd_divider.sv
// Half-period tick generator for the serial clock.
module adc_rd_divider #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int DW = $clog2(HALF_DIV + 1);

   logic [DW-1:0] div_q;

   assign tick = run && (div_q == DW'(HALF_DIV - 1));

   always_ff @(posedge clk) begin
      if (rst || !run || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end
endmodule

// File: rtl/adc_rd_shifter.sv
// Serial-in capture register, newest bit at position 0.
module adc_rd_shifter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             shift,
   input  logic             din,
   output logic [WIDTH-1:0] word
);
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         word[0] <= 1'b0;
      end else if (shift) begin
         word[0] <= din;
      end
   end

   for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst || clr) begin
            word[i] <= 1'b0;
         end else if (shift) begin
            word[i] <= word[i-1];
         end
      end
   end
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
   import adc_rd_pkg::*;
#(
   parameter int RES_BITS  = 12,
   parameter int HALF_DIV  = 3,
   parameter int SETUP_CYC = 2,
   parameter int GAP_CYC   = 7
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic                sdo_i,
   output logic                cs_n,
   output logic                sclk,
   output logic [RES_BITS-1:0] result,
   output logic                result_valid,
   output logic                frame_err
);
   localparam int TOT_BITS = RES_BITS + LEAD_BITS;
   localparam int BW       = $clog2(TOT_BITS + 1);

   // elaboration-time parameter checks
   if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
      $error("adc_readout_ctrl: RES_BITS must be 8, 10 or 12");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("adc_readout_ctrl: HALF_DIV must be at least 1");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("adc_readout_ctrl: SETUP_CYC must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("adc_readout_ctrl: GAP_CYC must be at least 1");
   end

   rd_state_t              state_q;
   logic                   cs_q, sclk_q, pend_q, valid_q, err_q;
   logic [BW-1:0]          bitcnt_q;
   logic [RES_BITS-1:0]    res_q;
   logic [TOT_BITS-1:0]    word;
   logic                   tick, setup_last, gap_last;
   logic                   launch, sample, frame_end;

   assign launch    = (state_q == ST_IDLE && start) ||
                      (state_q == ST_GAP && gap_last && (pend_q || start));
   assign sample    = (state_q == ST_SHIFT) && tick && !sclk_q;
   assign frame_end = (state_q == ST_SHIFT) && tick && sclk_q &&
                      (bitcnt_q == BW'(TOT_BITS));

   adc_rd_divider #(.HALF_DIV(HALF_DIV)) u_div (
      .clk (clk),
      .rst (rst),
      .run (state_q == ST_SHIFT),
      .tick(tick)
   );

   adc_rd_span #(.LIMIT(SETUP_CYC)) u_setup (
      .clk (clk),
      .rst (rst),
      .clr (launch),
      .en  (state_q == ST_SETUP),
      .last(setup_last)
   );

   adc_rd_span #(.LIMIT(GAP_CYC)) u_gap (
      .clk (clk),
      .rst (rst),
      .clr (frame_end),
      .en  (state_q == ST_GAP),
      .last(gap_last)
   );

   adc_rd_shifter #(.WIDTH(TOT_BITS)) u_shift (
      .clk  (clk),
      .rst  (rst),
      .clr  (launch),
      .shift(sample),
      .din  (sdo_i),
      .word (word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         cs_q     <= 1'b1;
         sclk_q   <= 1'b1;
         pend_q   <= 1'b0;
         valid_q  <= 1'b0;
         err_q    <= 1'b0;
         bitcnt_q <= '0;
         res_q    <= '0;
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;

         if (launch) begin
            pend_q <= 1'b0;
         end else if (start && state_q != ST_IDLE) begin
            pend_q <= 1'b1;
         end

         case (state_q)
            ST_IDLE: begin
               if (launch) begin
                  state_q  <= ST_SETUP;
                  cs_q     <= 1'b0;
                  bitcnt_q <= '0;
               end
            end
            ST_SETUP: begin
               if (setup_last) begin
                  state_q <= ST_SHIFT;
                  sclk_q  <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (sample) begin
                  sclk_q   <= 1'b1;
                  bitcnt_q <= bitcnt_q + 1'b1;
               end else if (frame_end) begin
                  state_q <= ST_GAP;
                  cs_q    <= 1'b1;
                  valid_q <= 1'b1;
                  res_q   <= word[RES_BITS-1:0];
                  err_q   <= |word[TOT_BITS-1 -: LEAD_BITS];
               end else if (tick) begin
                  sclk_q <= 1'b0;
               end
            end
            ST_GAP: begin
               if (launch) begin
                  state_q  <= ST_SETUP;
                  cs_q     <= 1'b0;
                  bitcnt_q <= '0;
               end else if (gap_last) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n         = cs_q;
   assign sclk         = sclk_q;
   assign result       = res_q;
   assign result_valid = valid_q;
   assign frame_err    = err_q;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
   parameter int RES_BITS = 12,
   parameter int HALF_DIV = 3,
   parameter int GAP_CYC  = 7
) (
   input logic clk,
   input logic rst,
   input logic cs_n,
   input logic sclk,
   input logic result_valid,
   input logic frame_err
);
   localparam int TOT = RES_BITS + 4;
   localparam int LW  = $clog2(HALF_DIV + 2);
   localparam int HW  = $clog2(GAP_CYC + 1);
   localparam int FW  = $clog2(TOT + 2);

   logic [LW-1:0] low_cnt;
   logic [HW-1:0] hi_cnt;
   logic [FW-1:0] fall_cnt;
   logic          sclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         low_cnt  <= '0;
         hi_cnt   <= HW'(GAP_CYC);
         fall_cnt <= '0;
         sclk_d   <= 1'b1;
      end else begin
         sclk_d <= sclk;
         if (!sclk) begin
            if (low_cnt != LW'(HALF_DIV + 1)) low_cnt <= low_cnt + 1'b1;
         end else begin
            low_cnt <= '0;
         end
         if (cs_n) begin
            if (hi_cnt != HW'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
            fall_cnt <= '0;
         end else begin
            hi_cnt <= '0;
            if (sclk_d && !sclk) fall_cnt <= fall_cnt + 1'b1;
         end
      end
   end

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> sclk);

   // R3
   sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sclk) |-> (low_cnt == LW'(HALF_DIV)));

   // R4
   fall_count_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (fall_cnt == FW'(TOT)));

   // R6
   valid_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
      result_valid |-> (cs_n && !$past(cs_n)));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      result_valid |=> !result_valid);

   // R7
   err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      frame_err |-> result_valid);

   // R8
   gap_min_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CYC)));
endmodule

bind adc_readout_ctrl adc_rd_chk #(
   .RES_BITS(RES_BITS),
   .HALF_DIV(HALF_DIV),
   .GAP_CYC (GAP_CYC)
) u_rd_chk (
   .clk         (clk),
   .rst         (rst),
   .cs_n        (cs_n),
   .sclk        (sclk),
   .result_valid(result_valid),
   .frame_err   (frame_err)
);

// File: tb/tb_adc_readout_ctrl.sv
`timescale 1ns/1ps
module tb_adc_readout_ctrl;
   localparam int HALF  = 3;
   localparam int SETUP = 2;
   localparam int GAP   = 7;
   localparam int TOT_A = 16;
   localparam int TOT_B = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // 12-bit instance
   logic        start_a = 1'b0;
   logic        sdo_a   = 1'b0;
   logic        cs_n_a, sclk_a, valid_a, err_a;
   logic [11:0] result_a;
   logic [15:0] fw_a = '0;
   int          ka = 0;

   // 8-bit instance
   logic        start_b = 1'b0;
   logic        sdo_b   = 1'b0;
   logic        cs_n_b, sclk_b, valid_b, err_b;
   logic [7:0]  result_b;
   logic [11:0] fw_b = '0;
   int          kb = 0;

   adc_readout_ctrl #(.RES_BITS(12), .HALF_DIV(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) dut (
      .clk(clk), .rst(rst), .start(start_a), .sdo_i(sdo_a), .cs_n(cs_n_a), .sclk(sclk_a),
      .result(result_a), .result_valid(valid_a), .frame_err(err_a));

   adc_readout_ctrl #(.RES_BITS(8), .HALF_DIV(HALF), .SETUP_CYC(SETUP), .GAP_CYC(GAP)) dut_b (
      .clk(clk), .rst(rst), .start(start_b), .sdo_i(sdo_b), .cs_n(cs_n_b), .sclk(sclk_b),
      .result(result_b), .result_valid(valid_b), .frame_err(err_b));

   // converter models: bit k appears after the k-th falling serial clock edge
   always @(negedge cs_n_a) ka = 0;
   always @(negedge sclk_a) if (!cs_n_a) begin
      ka = ka + 1;
      sdo_a <= (ka <= TOT_A) ? fw_a[TOT_A - ka] : 1'b0;
   end
   always @(negedge cs_n_b) kb = 0;
   always @(negedge sclk_b) if (!cs_n_b) begin
      kb = kb + 1;
      sdo_b <= (kb <= TOT_B) ? fw_b[TOT_B - kb] : 1'b0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      start_a = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n_a == 1'b1 && sclk_a == 1'b1, "R1 idle lines in reset", {cs_n_a, sclk_a}, 3);
      chk(valid_a == 1'b0 && err_a == 1'b0, "R1 strobes low in reset", {valid_a, err_a}, 0);
      start_a = 1'b0;
      rst = 1'b0;
      repeat (20) @(negedge clk);
      chk(cs_n_a == 1'b1, "R1 no frame from start seen in reset", cs_n_a, 1);
   endtask

   // one full frame on the 12-bit instance, started from idle
   task automatic t_frame_a(input logic [15:0] w);
      int c, seg, falls, badseg;
      logic prev, exp_err;
      logic [11:0] got;
      fw_a = w;
      exp_err = |w[15:12];
      @(negedge clk) start_a = 1'b1;
      @(negedge clk) start_a = 1'b0;
      chk(cs_n_a == 1'b0, "R2 cs_n low one edge after start", cs_n_a, 0);
      c = 0;
      while (sclk_a && c < 1000) begin @(negedge clk); c++; end
      chk(c == SETUP, "R2 setup cycles before first sclk fall", c, SETUP);
      falls = 1; seg = 0; prev = 1'b0; badseg = 0; c = 0;
      while (!cs_n_a && c < 5000) begin
         @(negedge clk);
         c++; seg++;
         if (sclk_a != prev) begin
            if (seg != HALF) badseg++;
            if (!sclk_a) falls++;
            prev = sclk_a;
            seg = 0;
         end
      end
      chk(badseg == 0, "R3 sclk phase lengths", badseg, 0);
      chk(falls == TOT_A, "R4 falling edges per 12-bit frame", falls, TOT_A);
      chk(seg == HALF, "R6 cs_n rise after last sclk rise", seg, HALF);
      chk(valid_a == 1'b1, "R6 valid with cs_n rise", valid_a, 1);
      chk(result_a == w[11:0], "R5 result bits", result_a, w[11:0]);
      chk(err_a == exp_err, "R7 leading bit error flag", err_a, exp_err);
      got = result_a;
      @(negedge clk);
      chk(valid_a == 1'b0 && err_a == 1'b0, "R6 single-cycle strobe", {valid_a, err_a}, 0);
      repeat (GAP + 3) @(negedge clk);
      chk(result_a == got, "R6 result held", result_a, got);
   endtask

   task automatic t_pending();
      int c, lows;
      fw_a = 16'h0_5A3;
      @(negedge clk) start_a = 1'b1;
      @(negedge clk) start_a = 1'b0;
      repeat (20) @(negedge clk);
      start_a = 1'b1; @(negedge clk); start_a = 1'b0;
      repeat (5) @(negedge clk);
      start_a = 1'b1; @(negedge clk); start_a = 1'b0;
      c = 0;
      while (!cs_n_a && c < 5000) begin @(negedge clk); c++; end
      chk(valid_a == 1'b1 && result_a == 12'h5A3, "R9 first frame intact", result_a, 12'h5A3);
      fw_a = 16'h0_C3E;
      c = 0;
      while (cs_n_a && c < 1000) begin @(negedge clk); c++; end
      chk(c == GAP, "R9 pending start served after gap", c, GAP);
      chk(c >= GAP, "R8 minimum cs_n high time", c, GAP);
      c = 0;
      while (!cs_n_a && c < 5000) begin @(negedge clk); c++; end
      chk(result_a == 12'hC3E, "R9 pending frame result", result_a, 12'hC3E);
      lows = 0;
      repeat (3 * GAP + 20) begin @(negedge clk); if (!cs_n_a) lows++; end
      chk(lows == 0, "R9 repeated requests give one frame", lows, 0);
   endtask

   task automatic t_reset_mid();
      int lows;
      fw_a = 16'h0_111;
      @(negedge clk) start_a = 1'b1;
      @(negedge clk) start_a = 1'b0;
      repeat (10) @(negedge clk);
      start_a = 1'b1; @(negedge clk); start_a = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n_a == 1'b1 && sclk_a == 1'b1, "R1 reset mid-frame idles lines", {cs_n_a, sclk_a}, 3);
      rst = 1'b0;
      lows = 0;
      repeat (60) begin @(negedge clk); if (!cs_n_a || valid_a) lows++; end
      chk(lows == 0, "R1 pending request dropped by reset", lows, 0);
   endtask

   task automatic t_res8(input logic [11:0] w);
      int c, falls;
      logic prev;
      fw_b = w;
      @(negedge clk) start_b = 1'b1;
      @(negedge clk) start_b = 1'b0;
      falls = 0; prev = sclk_b; c = 0;
      while (!cs_n_b && c < 5000) begin
         @(negedge clk);
         c++;
         if (prev && !sclk_b) falls++;
         prev = sclk_b;
      end
      chk(falls == TOT_B, "R4 falling edges per 8-bit frame", falls, TOT_B);
      chk(valid_b == 1'b1 && result_b == w[7:0], "R5 8-bit result", result_b, w[7:0]);
      chk(err_b == (|w[11:8]), "R7 8-bit error flag", err_b, |w[11:8]);
      repeat (GAP + 3) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_frame_a(16'h0_ABC);
      t_frame_a(16'h0_FFF);
      t_frame_a(16'h0_001);
      t_frame_a(16'h8_123);
      t_frame_a(16'h1_000);
      t_pending();
      t_reset_mid();
      t_res8(12'h0_A5);
      t_res8(12'h4_3C);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule